// File: doc/BRIEF.md
# Three-Phase Accumulator Processor Core

A small von Neumann processor with an 8-bit accumulator. One 256-byte memory inside the block holds both the program and its data. Each instruction is two bytes: an opcode byte and an address byte. Every instruction takes exactly three clocks: an opcode fetch, an operand fetch and an execute step. The opcodes fall into groups by their high nibble: data movement, arithmetic, bitwise logic and control flow. One of the conditional branches tests a one-bit external switch.

A program is loaded through a backdoor write port while `rst_n` is held low. When reset is released, execution starts at address 0. A halt opcode freezes the core until the next reset. Debug outputs show the program counter, the instruction register, the address register, the accumulator and the current phase on every cycle.

Top module: `acc8_core`

## Requirements
- R1: The phase shown on `dbg_phase_o` follows 0 (opcode fetch), then 1 (operand fetch), then 2 (execute), then back to 0. It never takes the value 3.
- R2: In phase 0 the instruction register loads the memory byte at PC. In phase 1 the address register loads the memory byte at PC. In each of these two phases PC increments modulo 256, so a fetch from 0xFF is followed by a fetch from 0x00. The debug outputs show the registers as they are after each clock edge.
- R3: Opcode 0x00 changes nothing. 0x01 sets the accumulator to zero. 0x02 loads the accumulator with the memory byte at AR. 0x03 writes the accumulator into memory at AR on the execute clock edge.
- R4: Opcode 0x10 adds one to the accumulator and 0x11 subtracts one. 0x12 adds the memory byte at AR and 0x13 subtracts it. All results wrap modulo 256 and no flag is kept.
- R5: Opcode 0x20 inverts every accumulator bit. 0x21, 0x22 and 0x23 combine the memory byte at AR into the accumulator with AND, OR and XOR.
- R6: Opcode 0x40 always sets PC to AR. 0x41 sets PC to AR only when the accumulator is zero. 0x42 does so only when accumulator bit 7 is one. 0x45 does so only when `switch_i` is 1. When a branch is not taken, PC keeps its incremented value.
- R7: Opcode 0xFF raises `halted_o` and returns the phase to 0. From then on, no register and no memory byte changes until reset.
- R8: Any opcode value not listed above behaves as a no-op. The phase sequence and the PC steps are unaffected.
- R9: A low `rst_n` asynchronously clears PC, the instruction register, the address register, the accumulator, the phase and the halted state. After `rst_n` rises, the core stays in reset for two more rising clock edges and executes from the third.
- R10: A write on the load port (`load_en_i`, `load_addr_i`, `load_data_i`) is stored on a rising clock edge only while the core is in reset. While the core runs, the load port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| switch_i | input | 1 | External switch bit tested by opcode 0x45 |
| load_en_i | input | 1 | Load port write strobe, used only during reset |
| load_addr_i | input | 8 | Load port byte address |
| load_data_i | input | 8 | Load port byte value |
| halted_o | output | 1 | High after a halt opcode has executed |
| dbg_pc_o | output | 8 | Program counter |
| dbg_ir_o | output | 8 | Instruction register (current opcode) |
| dbg_ar_o | output | 8 | Address register (current operand) |
| dbg_acc_o | output | 8 | Accumulator |
| dbg_phase_o | output | 2 | Current phase: 0 opcode fetch, 1 operand fetch, 2 execute |

## Verification
The bound checker watches on every cycle:
- the legal phase order;
- the PC step in both fetch phases;
- that the accumulator holds outside execute and AR holds outside the operand fetch;
- that the core is fully frozen and writes no memory once halted;
- that memory writes during a run happen only in the execute phase;
- the cleared state while reset is applied.

Only the bench scenarios can show the data results of each opcode, whether a branch is taken or not, the PC wrap at 0xFF, and that a stored byte wins over load port writes attempted during a run. The bench reads these back through later loads and compares each cycle with a reference model.

// File: rtl/acc8_pkg.sv
`timescale 1ns/1ps
package acc8_pkg;

  localparam int OPC_W = 8;

  // opcode values; the high nibble selects the group
  localparam logic [OPC_W-1:0] OP_NOP   = 8'h00;
  localparam logic [OPC_W-1:0] OP_CLR   = 8'h01;
  localparam logic [OPC_W-1:0] OP_LOAD  = 8'h02;
  localparam logic [OPC_W-1:0] OP_STORE = 8'h03;
  localparam logic [OPC_W-1:0] OP_INC   = 8'h10;
  localparam logic [OPC_W-1:0] OP_DEC   = 8'h11;
  localparam logic [OPC_W-1:0] OP_ADD   = 8'h12;
  localparam logic [OPC_W-1:0] OP_SUB   = 8'h13;
  localparam logic [OPC_W-1:0] OP_INV   = 8'h20;
  localparam logic [OPC_W-1:0] OP_AND   = 8'h21;
  localparam logic [OPC_W-1:0] OP_OR    = 8'h22;
  localparam logic [OPC_W-1:0] OP_XOR   = 8'h23;
  localparam logic [OPC_W-1:0] OP_JMP   = 8'h40;
  localparam logic [OPC_W-1:0] OP_BZ    = 8'h41;
  localparam logic [OPC_W-1:0] OP_BNEG  = 8'h42;
  localparam logic [OPC_W-1:0] OP_BSW   = 8'h45;
  localparam logic [OPC_W-1:0] OP_HALT  = 8'hFF;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_OPR = 2'd1,
    PH_EXE = 2'd2
  } phase_e;

endpackage

// File: rtl/acc8_rst_sync.sv
`timescale 1ns/1ps
module acc8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  generate
    if (STAGES == 1) begin : g_single
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_sync_n = sync_q;
    end else begin : g_chain
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = sync_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/acc8_mem.sv
`timescale 1ns/1ps
module acc8_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cell_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cell_q[wr_addr] <= wr_data;
  end

  assign rd_data = cell_q[rd_addr];

endmodule

// File: rtl/acc8_alu.sv
`timescale 1ns/1ps
module acc8_alu
  import acc8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic [DW-1:0]    acc,
  input  logic [DW-1:0]    operand,
  input  logic             switch_bit,
  output logic [DW-1:0]    acc_nxt,
  output logic             acc_upd,
  output logic             pc_take,
  output logic             mem_store,
  output logic             halt_req
);

  localparam logic [DW-1:0] ONE = DW'(1);

  always_comb begin
    acc_nxt   = acc;
    acc_upd   = 1'b0;
    pc_take   = 1'b0;
    mem_store = 1'b0;
    halt_req  = 1'b0;
    case (opcode)
      OP_CLR:   begin acc_nxt = '0;             acc_upd = 1'b1; end
      OP_LOAD:  begin acc_nxt = operand;        acc_upd = 1'b1; end
      OP_STORE: mem_store = 1'b1;
      OP_INC:   begin acc_nxt = acc + ONE;      acc_upd = 1'b1; end
      OP_DEC:   begin acc_nxt = acc - ONE;      acc_upd = 1'b1; end
      OP_ADD:   begin acc_nxt = acc + operand;  acc_upd = 1'b1; end
      OP_SUB:   begin acc_nxt = acc - operand;  acc_upd = 1'b1; end
      OP_INV:   begin acc_nxt = ~acc;           acc_upd = 1'b1; end
      OP_AND:   begin acc_nxt = acc & operand;  acc_upd = 1'b1; end
      OP_OR:    begin acc_nxt = acc | operand;  acc_upd = 1'b1; end
      OP_XOR:   begin acc_nxt = acc ^ operand;  acc_upd = 1'b1; end
      OP_JMP:   pc_take = 1'b1;
      OP_BZ:    pc_take = (acc == '0);
      OP_BNEG:  pc_take = acc[DW-1];
      OP_BSW:   pc_take = switch_bit;
      OP_HALT:  halt_req = 1'b1;
      default:  ;  // no-op, including every unlisted value
    endcase
  end

endmodule

// File: rtl/acc8_core.sv
`timescale 1ns/1ps
module acc8_core
  import acc8_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          switch_i,
  input  logic          load_en_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic [DW-1:0] load_data_i,
  output logic          halted_o,
  output logic [AW-1:0] dbg_pc_o,
  output logic [DW-1:0] dbg_ir_o,
  output logic [AW-1:0] dbg_ar_o,
  output logic [DW-1:0] dbg_acc_o,
  output logic [1:0]    dbg_phase_o
);

  localparam logic [AW-1:0] PC_STEP = AW'(1);

  logic          core_rst_n;
  phase_e        ph_q, ph_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q, ir_d;
  logic [AW-1:0] ar_q, ar_d;
  logic [DW-1:0] acc_q, acc_d;
  logic          hlt_q, hlt_d;
  logic          core_en;

  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  logic [DW-1:0] alu_acc;
  logic          alu_acc_upd;
  logic          alu_take;
  logic          alu_store;
  logic          alu_halt;

  acc8_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  // fetches address by PC, execute addresses by AR
  assign mem_raddr = (ph_q == PH_EXE) ? ar_q : pc_q;

  // during reset only the load port reaches memory; while running only the store opcode does
  always_comb begin
    if (!core_rst_n) begin
      mem_we    = load_en_i;
      mem_waddr = load_addr_i;
      mem_wdata = load_data_i;
    end else begin
      mem_we    = core_en && (ph_q == PH_EXE) && alu_store;
      mem_waddr = ar_q;
      mem_wdata = acc_q;
    end
  end

  acc8_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (mem_waddr),
    .wr_data (mem_wdata),
    .rd_addr (mem_raddr),
    .rd_data (mem_rdata)
  );

  acc8_alu #(.DW(DW)) u_alu (
    .opcode     (OPC_W'(ir_q)),
    .acc        (acc_q),
    .operand    (mem_rdata),
    .switch_bit (switch_i),
    .acc_nxt    (alu_acc),
    .acc_upd    (alu_acc_upd),
    .pc_take    (alu_take),
    .mem_store  (alu_store),
    .halt_req   (alu_halt)
  );

  assign core_en = !hlt_q;

  // next-state logic
  always_comb begin
    ph_d  = ph_q;
    pc_d  = pc_q;
    ir_d  = ir_q;
    ar_d  = ar_q;
    acc_d = acc_q;
    hlt_d = hlt_q;
    unique case (ph_q)
      PH_OPC: begin
        ir_d = mem_rdata;
        pc_d = pc_q + PC_STEP;
        ph_d = PH_OPR;
      end
      PH_OPR: begin
        ar_d = AW'(mem_rdata);
        pc_d = pc_q + PC_STEP;
        ph_d = PH_EXE;
      end
      PH_EXE: begin
        if (alu_acc_upd) acc_d = alu_acc;
        if (alu_take)    pc_d  = ar_q;
        if (alu_halt)    hlt_d = 1'b1;
        ph_d = PH_OPC;
      end
      default: ph_d = PH_OPC;
    endcase
  end

  // state registers, enabled while not halted
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ph_q  <= PH_OPC;
      pc_q  <= '0;
      ir_q  <= '0;
      ar_q  <= '0;
      acc_q <= '0;
      hlt_q <= 1'b0;
    end else if (core_en) begin
      ph_q  <= ph_d;
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      ar_q  <= ar_d;
      acc_q <= acc_d;
      hlt_q <= hlt_d;
    end
  end

  assign halted_o    = hlt_q;
  assign dbg_pc_o    = pc_q;
  assign dbg_ir_o    = ir_q;
  assign dbg_ar_o    = ar_q;
  assign dbg_acc_o   = acc_q;
  assign dbg_phase_o = ph_q;

endmodule

// File: rtl/acc8_core_chk.sv
`timescale 1ns/1ps
module acc8_core_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_rst_n,
  input logic          halted,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] ir,
  input logic [AW-1:0] ar,
  input logic [DW-1:0] acc,
  input logic [1:0]    phase,
  input logic          mem_we
);

  p_phase_legal_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    phase != 2'd3);

  p_opc_to_opr_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!halted && phase == 2'd0) |=> phase == 2'd1);

  p_opr_to_exe_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == 2'd1) |=> phase == 2'd2);

  p_exe_to_opc_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == 2'd2) |=> phase == 2'd0);

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!halted && phase != 2'd2) |=> pc == AW'($past(pc) + AW'(1)));

  p_ar_hold_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase != 2'd1) |=> $stable(ar));

  p_acc_hold_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase != 2'd2) |=> $stable(acc));

  p_halt_freeze_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> (halted && $stable(pc) && $stable(ir) && $stable(ar)
                && $stable(acc) && $stable(phase)));

  p_halt_no_write_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |-> !mem_we);

  p_run_write_exe_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_we |-> phase == 2'd2);

  p_reset_clear_r9: assert property (@(posedge clk)
    !rst_n |-> (pc == '0 && ir == '0 && ar == '0 && acc == '0
                && phase == 2'd0 && !halted));

endmodule

bind acc8_core acc8_core_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .halted     (halted_o),
  .pc         (dbg_pc_o),
  .ir         (dbg_ir_o),
  .ar         (dbg_ar_o),
  .acc        (dbg_acc_o),
  .phase      (dbg_phase_o),
  .mem_we     (mem_we)
);

// File: tb/acc8_core_bench.sv
`timescale 1ns/1ps
module acc8_core_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       switch_i;
  logic       load_en_i;
  logic [7:0] load_addr_i;
  logic [7:0] load_data_i;
  logic       halted_o;
  logic [7:0] dbg_pc_o, dbg_ir_o, dbg_ar_o, dbg_acc_o;
  logic [1:0] dbg_phase_o;

  always #5 clk = ~clk;

  acc8_core u_acc8_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .switch_i    (switch_i),
    .load_en_i   (load_en_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .halted_o    (halted_o),
    .dbg_pc_o    (dbg_pc_o),
    .dbg_ir_o    (dbg_ir_o),
    .dbg_ar_o    (dbg_ar_o),
    .dbg_acc_o   (dbg_acc_o),
    .dbg_phase_o (dbg_phase_o)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0] m_mem [256];
  logic [7:0] m_pc, m_ir, m_ar, m_acc;
  logic [1:0] m_ph;
  logic       m_halt;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 0; m_ir = 0; m_ar = 0; m_acc = 0; m_ph = 0; m_halt = 1'b0;
  endtask

  // one rising edge of a running core, from the requirements
  task automatic model_step(input logic sw);
    if (!m_halt) begin
      case (m_ph)
        2'd0: begin m_ir = m_mem[m_pc]; m_pc = m_pc + 8'd1; m_ph = 2'd1; end
        2'd1: begin m_ar = m_mem[m_pc]; m_pc = m_pc + 8'd1; m_ph = 2'd2; end
        default: begin
          m_ph = 2'd0;
          case (m_ir)
            8'h01: m_acc = 8'h00;
            8'h02: m_acc = m_mem[m_ar];
            8'h03: m_mem[m_ar] = m_acc;
            8'h10: m_acc = m_acc + 8'd1;
            8'h11: m_acc = m_acc - 8'd1;
            8'h12: m_acc = m_acc + m_mem[m_ar];
            8'h13: m_acc = m_acc - m_mem[m_ar];
            8'h20: m_acc = ~m_acc;
            8'h21: m_acc = m_acc & m_mem[m_ar];
            8'h22: m_acc = m_acc | m_mem[m_ar];
            8'h23: m_acc = m_acc ^ m_mem[m_ar];
            8'h40: m_pc = m_ar;
            8'h41: if (m_acc == 8'h00) m_pc = m_ar;
            8'h42: if (m_acc[7]) m_pc = m_ar;
            8'h45: if (sw) m_pc = m_ar;
            8'hFF: m_halt = 1'b1;
            default: ;
          endcase
        end
      endcase
    end
  endtask

  task automatic cmp_model();
    chk("R1 phase trace",    {6'd0, dbg_phase_o}, {6'd0, m_ph});
    chk("R2 pc trace",       dbg_pc_o,  m_pc);
    chk("R2 ir trace",       dbg_ir_o,  m_ir);
    chk("R2 ar trace",       dbg_ar_o,  m_ar);
    chk("R2 acc trace",      dbg_acc_o, m_acc);
    chk("R7 halted trace",   {7'd0, halted_o}, {7'd0, m_halt});
  endtask

  // inputs are already set at a falling edge; advance one clock
  task automatic tick();
    model_step(switch_i);
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic instr();
    repeat (3) tick();
  endtask

  // holds the core in reset, loads m_mem through the load port, releases
  task automatic reset_load();
    @(negedge clk);
    rst_n = 1'b0;
    load_en_i = 1'b0;
    @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      load_en_i   = 1'b1;
      load_addr_i = 8'(a);
      load_data_i = m_mem[a];
      @(negedge clk);
    end
    load_en_i = 1'b0;
    rst_n = 1'b1;
    model_reset();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R9 reset pc",    dbg_pc_o, 8'h00);
    chk("R9 reset acc",   dbg_acc_o, 8'h00);
    chk("R9 reset ir",    dbg_ir_o, 8'h00);
    chk("R9 reset ar",    dbg_ar_o, 8'h00);
    chk("R9 reset phase", {6'd0, dbg_phase_o}, 8'h00);
    chk("R9 reset halt",  {7'd0, halted_o}, 8'h00);
  endtask

  task automatic put(input logic [7:0] addr, input logic [7:0] op, input logic [7:0] opr);
    m_mem[addr] = op;
    m_mem[addr + 8'd1] = opr;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    switch_i = 1'b0;
    load_en_i = 1'b0;
    load_addr_i = 8'h00;
    load_data_i = 8'h00;
    void'($urandom(32'h5eed_0a11));

    // directed program covering every opcode group
    for (int a = 0; a < 256; a++) m_mem[a] = 8'h00;
    put(8'h00, 8'h01, 8'h00);  // clear
    put(8'h02, 8'h11, 8'h00);  // decrement
    put(8'h04, 8'h41, 8'h20);  // zero branch, not taken
    put(8'h06, 8'h42, 8'h0A);  // negative branch, taken
    put(8'h08, 8'hFF, 8'h00);
    put(8'h0A, 8'h10, 8'h00);  // increment
    put(8'h0C, 8'h41, 8'h10);  // zero branch, taken
    put(8'h0E, 8'hFF, 8'h00);
    put(8'h10, 8'h02, 8'hF0);
    put(8'h12, 8'h12, 8'hF1);
    put(8'h14, 8'h13, 8'hF1);
    put(8'h16, 8'h20, 8'h00);
    put(8'h18, 8'h21, 8'hF2);
    put(8'h1A, 8'h22, 8'hF3);
    put(8'h1C, 8'h23, 8'hF4);
    put(8'h1E, 8'h03, 8'hF5);  // store
    put(8'h20, 8'h01, 8'h00);
    put(8'h22, 8'h02, 8'hF5);  // reload
    put(8'h24, 8'h45, 8'h40);
    put(8'h26, 8'h45, 8'h40);
    put(8'h28, 8'hFF, 8'h00);
    put(8'h40, 8'h77, 8'h00);  // unlisted opcode
    put(8'h42, 8'h00, 8'h00);  // nop
    put(8'h44, 8'h40, 8'h50);  // jump
    put(8'h50, 8'hFF, 8'h00);  // halt
    m_mem[8'hF0] = 8'h7F; m_mem[8'hF1] = 8'h81; m_mem[8'hF2] = 8'hF0;
    m_mem[8'hF3] = 8'h0F; m_mem[8'hF4] = 8'hFF; m_mem[8'hF5] = 8'h33;
    reset_load();

    // load port held active for the whole run: must be ignored (R10)
    load_en_i = 1'b1; load_addr_i = 8'hF5; load_data_i = 8'hAA;
    instr();
    instr(); chk("R4 decrement wraps to FF", dbg_acc_o, 8'hFF);
    instr(); chk("R6 zero branch not taken", dbg_pc_o, 8'h06);
    instr(); chk("R6 negative branch taken", dbg_pc_o, 8'h0A);
    instr(); chk("R4 increment wraps to 00", dbg_acc_o, 8'h00);
    instr(); chk("R6 zero branch taken", dbg_pc_o, 8'h10);
    instr(); chk("R3 load", dbg_acc_o, 8'h7F);
    instr(); chk("R4 add wraps", dbg_acc_o, 8'h00);
    instr(); chk("R4 subtract wraps", dbg_acc_o, 8'h7F);
    instr(); chk("R5 invert", dbg_acc_o, 8'h80);
    instr(); chk("R5 and", dbg_acc_o, 8'h80);
    instr(); chk("R5 or", dbg_acc_o, 8'h8F);
    instr(); chk("R5 xor", dbg_acc_o, 8'h70);
    instr();
    instr(); chk("R3 clear", dbg_acc_o, 8'h00);
    instr(); chk("R3 R10 stored byte read back, load port ignored", dbg_acc_o, 8'h70);
    instr(); chk("R6 switch branch not taken", dbg_pc_o, 8'h26);
    switch_i = 1'b1;
    instr(); chk("R6 switch branch taken", dbg_pc_o, 8'h40);
    switch_i = 1'b0;
    instr(); chk("R8 unlisted opcode pc", dbg_pc_o, 8'h42);
             chk("R8 unlisted opcode acc", dbg_acc_o, 8'h70);
    instr(); chk("R3 nop pc", dbg_pc_o, 8'h44);
    instr(); chk("R6 jump", dbg_pc_o, 8'h50);
    instr(); chk("R7 halted raised", {7'd0, halted_o}, 8'h01);
    repeat (9) tick();
    chk("R7 halted pc frozen", dbg_pc_o, 8'h52);
    chk("R7 halted acc frozen", dbg_acc_o, 8'h70);
    chk("R7 halted phase", {6'd0, dbg_phase_o}, 8'h00);
    load_en_i = 1'b0;

    // PC wrap from FF to 00 (reset also clears halted)
    for (int a = 0; a < 256; a++) m_mem[a] = 8'h00;
    put(8'h00, 8'h40, 8'hFE);
    put(8'hFE, 8'h10, 8'h00);
    reset_load();
    instr(); chk("R6 jump to FE", dbg_pc_o, 8'hFE);
    instr(); chk("R2 pc wraps past FF", dbg_pc_o, 8'h00);
             chk("R2 operand fetched from FF", dbg_ar_o, 8'h00);
             chk("R4 increment", dbg_acc_o, 8'h01);

    // random programs against the model
    for (int p = 0; p < 12; p++) begin
      for (int a = 0; a < 256; a++) begin
        if ((a % 2) == 0 && ($urandom % 8) != 0) begin
          case ($urandom % 16)
            0: m_mem[a] = 8'h00;  1: m_mem[a] = 8'h01;
            2: m_mem[a] = 8'h02;  3: m_mem[a] = 8'h03;
            4: m_mem[a] = 8'h10;  5: m_mem[a] = 8'h11;
            6: m_mem[a] = 8'h12;  7: m_mem[a] = 8'h13;
            8: m_mem[a] = 8'h20;  9: m_mem[a] = 8'h21;
            10: m_mem[a] = 8'h22; 11: m_mem[a] = 8'h23;
            12: m_mem[a] = 8'h40; 13: m_mem[a] = 8'h41;
            14: m_mem[a] = 8'h42; default: m_mem[a] = 8'h45;
          endcase
        end else begin
          m_mem[a] = 8'($urandom);
        end
      end
      reset_load();
      for (int c = 0; c < 300; c++) begin
        switch_i    = 1'($urandom);
        load_en_i   = 1'($urandom);
        load_addr_i = 8'($urandom);
        load_data_i = 8'($urandom);
        tick();
      end
      load_en_i = 1'b0;
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule